// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Controller

This block is the shared messaging point of a small multi-core cluster. A writer presents a 64-bit command for one clock cycle. A command-type input selects one of two actions. The first raises an interrupt vector on a target core. The second deposits a 32-bit word into one of that core's eight mailbox slots. A per-byte mask lets the writer keep selected bytes of the stored word and replace only the others, so several senders can fill different bytes of one slot without a read-modify-write round trip.

Each core owns four pieces of state:
- a 32-bit status register,
- a 32-bit enable register,
- a write-only clear port,
- eight mailbox words.

A read port returns status, enable or a mailbox word for a selected core. There is one interrupt line per core. It is high when any status bit that is also enabled is set, and it follows the status register one cycle later.

Top module: `ipi_mbox_unit`

## Requirements
- R1: After reset (active-low `rst_ni`), every status, enable and mailbox word reads zero and every `irq_o` bit is 0.
- R2: A command with `cmd_kind_i`=0 (IPI send) ORs the value 1<<`cmd_data_i[4:0]` into the status register of core `cmd_data_i[25:16]`. The other bits of that register and the other cores are unchanged.
- R3: A command with `cmd_kind_i`=1 (mailbox send) writes mailbox word `cmd_data_i[4:2]` of core `cmd_data_i[25:16]`. Every other word is unchanged.
- R4: In a mailbox send, bit 27+i of the command covers byte i (bits 8i+7:8i) of the word. If that bit is 1, the byte keeps its stored value. If it is 0, the byte takes byte i of `cmd_data_i[63:32]`.
- R5: A mailbox send with `cmd_data_i[30:27]`=0 stores `cmd_data_i[63:32]` whole.
- R6: A command whose core number `cmd_data_i[25:16]` is NUM_CORES or more changes no state.
- R7: A write on the clear port clears the status bits that are 1 in `clr_data_i` for core `clr_core_i`. When an IPI send sets a bit in the same cycle that the bit is cleared, the bit ends up set.
- R8: `irq_o[c]` equals the OR of (status AND enable) of core c as it stood one cycle earlier.
- R9: A write on the enable port loads `en_data_i` into the enable register of core `en_core_i`.
- R10: Read offsets on `rd_addr_i`: 0x00 returns status, 0x04 returns enable, and 0x20+4k returns mailbox word k (k = 0..7). Any other offset returns zero. The read is combinational.
- R11: While `cmd_valid_i` is 0, the command inputs change no state.
- R12: State changes take effect on the rising clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_kind_i | input | 1 | 0 = IPI send, 1 = mailbox send |
| cmd_data_i | input | 64 | Command word |
| en_we_i | input | 1 | Enable register write strobe |
| en_core_i | input | 2 | Core whose enable register is written |
| en_data_i | input | 32 | New enable value |
| clr_we_i | input | 1 | Status clear strobe |
| clr_core_i | input | 2 | Core whose status is cleared |
| clr_data_i | input | 32 | Bits to clear |
| rd_core_i | input | 2 | Core selected for reading |
| rd_addr_i | input | 6 | Register offset within the core window |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 4 | Interrupt line per core |

## Verification
The assertions take for granted a single writer: at most one command per cycle, with the core number, word index and mask valid whenever `cmd_valid_i` is high. They also take for granted that clear and enable writes name an existing core.

The bench meets these assumptions. It changes every input only on the falling clock edge and holds each strobe high for exactly one cycle. Core numbers out of range appear only in the commands that test R6. Mailbox sends sweep every core, every word and all sixteen masks in two passes. The second pass proves that masked bytes survive earlier writes.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int unsigned CMD_W       = 64;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CORE_ID_W   = 10;
  localparam int unsigned CORE_ID_LSB = 16;
  localparam int unsigned VEC_W       = 5;
  localparam int unsigned MB_IDX_W    = 3;
  localparam int unsigned MB_IDX_LSB  = 2;
  localparam int unsigned KEEP_W      = 4;
  localparam int unsigned KEEP_LSB    = 27;
  localparam int unsigned PAYLOAD_LSB = 32;
  localparam int unsigned NUM_MBOX    = 1 << MB_IDX_W;
  localparam int unsigned OFS_W       = 6;

  localparam logic [OFS_W-1:0] OFS_STATUS = 6'h00;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 6'h04;
  localparam logic [OFS_W-1:0] OFS_MBOX   = 6'h20;

  typedef enum logic {
    KIND_IPI  = 1'b0,
    KIND_MAIL = 1'b1
  } cmd_kind_e;

  typedef struct packed {
    logic [CORE_ID_W-1:0] core;
    logic [VEC_W-1:0]     vec;
    logic [MB_IDX_W-1:0]  mb_idx;
    logic [KEEP_W-1:0]    keep;
    logic [WORD_W-1:0]    payload;
  } cmd_fields_t;

  function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] c);
    cmd_fields_t f;
    f.core    = c[CORE_ID_LSB +: CORE_ID_W];
    f.vec     = c[0 +: VEC_W];
    f.mb_idx  = c[MB_IDX_LSB +: MB_IDX_W];
    f.keep    = c[KEEP_LSB +: KEEP_W];
    f.payload = c[PAYLOAD_LSB +: WORD_W];
    return f;
  endfunction
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic                 cmd_kind_i,
  input  logic [CMD_W-1:0]     cmd_data_i,
  output logic [NUM_CORES-1:0] core_hit_o,
  output logic                 ipi_go_o,
  output logic                 mbx_go_o,
  output cmd_fields_t          fields_o
);
  logic in_range;

  assign fields_o = split_cmd(cmd_data_i);
  assign in_range = fields_o.core < CORE_ID_W'(NUM_CORES);
  assign ipi_go_o = cmd_kind_i == KIND_IPI;
  assign mbx_go_o = cmd_kind_i == KIND_MAIL;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
    assign core_hit_o[i] = cmd_valid_i && in_range && (fields_o.core == CORE_ID_W'(i));
  end

  // R6
  oor_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fields_o.core >= CORE_ID_W'(NUM_CORES)) |-> (core_hit_o == '0));

  // R11
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_hit_o) && (!cmd_valid_i -> core_hit_o == '0));
endmodule

// File: rtl/ipi_mbox_merge.sv
module ipi_mbox_merge
  import ipi_mbox_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] new_i,
  input  logic [KEEP_W-1:0] keep_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned BYTE_W = WORD_W / KEEP_W;

  for (genvar b = 0; b < KEEP_W; b++) begin : g_byte
    assign word_o[b*BYTE_W +: BYTE_W] = keep_i[b] ? old_i[b*BYTE_W +: BYTE_W]
                                                  : new_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_mbox_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ipi_set_i,
  input  logic [VEC_W-1:0]    vec_i,
  input  logic                mbx_we_i,
  input  logic [MB_IDX_W-1:0] mb_idx_i,
  input  logic [KEEP_W-1:0]   keep_i,
  input  logic [WORD_W-1:0]   payload_i,
  input  logic                en_we_i,
  input  logic [WORD_W-1:0]   en_data_i,
  input  logic                clr_we_i,
  input  logic [WORD_W-1:0]   clr_data_i,
  input  logic [OFS_W-1:0]    rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                irq_o
);
  localparam int unsigned BYTE_W = WORD_W / KEEP_W;

  logic [WORD_W-1:0] status_q, status_d, en_q;
  logic [WORD_W-1:0] set_vec, clr_vec, merged, keep_bits;
  logic [WORD_W-1:0] mbox_q [NUM_MBOX];
  logic              irq_q;

  assign set_vec  = ipi_set_i ? (WORD_W'(1) << vec_i) : '0;
  assign clr_vec  = clr_we_i ? clr_data_i : '0;
  // set wins over clear on the same bit
  assign status_d = (status_q & ~clr_vec) | set_vec;

  for (genvar b = 0; b < KEEP_W; b++) begin : g_keep
    assign keep_bits[b*BYTE_W +: BYTE_W] = {BYTE_W{keep_i[b]}};
  end

  ipi_mbox_merge u_merge (
    .old_i  (mbox_q[mb_idx_i]),
    .new_i  (payload_i),
    .keep_i (keep_i),
    .word_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
      for (int k = 0; k < NUM_MBOX; k++) mbox_q[k] <= '0;
    end else begin
      status_q <= status_d;
      irq_q    <= |(status_q & en_q);
      if (en_we_i)  en_q <= en_data_i;
      if (mbx_we_i) mbox_q[mb_idx_i] <= merged;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == OFS_STATUS)      rd_data_o = status_q;
    else if (rd_addr_i == OFS_ENABLE) rd_data_o = en_q;
    else if (rd_addr_i[OFS_W-1] && rd_addr_i[1:0] == 2'b00)
      rd_data_o = mbox_q[rd_addr_i[MB_IDX_LSB +: MB_IDX_W]];
  end

  assign irq_o = irq_q;

  // R2
  ipi_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_set_i |=> status_q[$past(vec_i)]);

  // R7
  clr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_q & $past(clr_data_i) & ~$past(set_vec)) == '0));

  // R4
  keep_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_we_i |=> (((mbox_q[$past(mb_idx_i)] ^ $past(mbox_q[mb_idx_i])) & $past(keep_bits)) == '0));

  // R5
  new_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_we_i |=> (((mbox_q[$past(mb_idx_i)] ^ $past(payload_i)) & ~$past(keep_bits)) == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (irq_o == $past(|(status_q & en_q))));
endmodule

// File: rtl/ipi_mbox_unit.sv
module ipi_mbox_unit
  import ipi_mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CSEL_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic                 cmd_kind_i,
  input  logic [63:0]          cmd_data_i,
  input  logic                 en_we_i,
  input  logic [CSEL_W-1:0]    en_core_i,
  input  logic [31:0]          en_data_i,
  input  logic                 clr_we_i,
  input  logic [CSEL_W-1:0]    clr_core_i,
  input  logic [31:0]          clr_data_i,
  input  logic [CSEL_W-1:0]    rd_core_i,
  input  logic [5:0]           rd_addr_i,
  output logic [31:0]          rd_data_o,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [NUM_CORES-1:0] core_hit;
  logic                 ipi_go, mbx_go;
  cmd_fields_t          fields;
  logic [WORD_W-1:0]    core_rd [NUM_CORES];

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_kind_i  (cmd_kind_i),
    .cmd_data_i  (cmd_data_i),
    .core_hit_o  (core_hit),
    .ipi_go_o    (ipi_go),
    .mbx_go_o    (mbx_go),
    .fields_o    (fields)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    ipi_core_regs u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ipi_set_i  (core_hit[i] && ipi_go),
      .vec_i      (fields.vec),
      .mbx_we_i   (core_hit[i] && mbx_go),
      .mb_idx_i   (fields.mb_idx),
      .keep_i     (fields.keep),
      .payload_i  (fields.payload),
      .en_we_i    (en_we_i && en_core_i == CSEL_W'(i)),
      .en_data_i  (en_data_i),
      .clr_we_i   (clr_we_i && clr_core_i == CSEL_W'(i)),
      .clr_data_i (clr_data_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (core_rd[i]),
      .irq_o      (irq_o[i])
    );
  end

  assign rd_data_o = (32'(rd_core_i) < NUM_CORES) ? core_rd[rd_core_i] : '0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/ipi_mbox_unit_tb.sv
`timescale 1ns/1ps
module ipi_mbox_unit_tb;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 0, cmd_kind_i = 0;
  logic [63:0] cmd_data_i = '0;
  logic        en_we_i = 0, clr_we_i = 0;
  logic [1:0]  en_core_i = '0, clr_core_i = '0, rd_core_i = '0;
  logic [31:0] en_data_i = '0, clr_data_i = '0;
  logic [5:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [NC-1:0] irq_o;

  int checks = 0, errors = 0;
  logic [31:0] m_st [NC];
  logic [31:0] m_en [NC];
  logic [31:0] m_mb [NC][8];

  always #2.5 clk = ~clk;

  ipi_mbox_unit #(.NUM_CORES(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_kind_i(cmd_kind_i),
    .cmd_data_i(cmd_data_i), .en_we_i(en_we_i), .en_core_i(en_core_i), .en_data_i(en_data_i),
    .clr_we_i(clr_we_i), .clr_core_i(clr_core_i), .clr_data_i(clr_data_i),
    .rd_core_i(rd_core_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic rd(input int core, input logic [5:0] addr, output logic [31:0] d);
    rd_core_i = 2'(core);
    rd_addr_i = addr;
    #1;
    d = rd_data_o;
  endtask

  function automatic logic [63:0] mk_cmd(input logic [31:0] pay, input logic [3:0] keep,
                                         input logic [9:0] core, input logic [4:0] low);
    return {pay, 1'b0, keep, 1'b0, core, 11'b0, low};
  endfunction

  // one command cycle, optional clear in the same cycle; ends on the next falling edge
  task automatic cmd(input logic valid, input logic kind, input logic [63:0] data,
                     input logic clr, input int clr_core, input logic [31:0] clr_bits);
    cmd_valid_i = valid; cmd_kind_i = kind; cmd_data_i = data;
    clr_we_i = clr; clr_core_i = 2'(clr_core); clr_data_i = clr_bits;
    @(negedge clk);
    cmd_valid_i = 0; clr_we_i = 0; cmd_data_i = '0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      rd(c, 6'h00, d); chk(d, m_st[c], $sformatf("%s status core%0d", tag, c));
      rd(c, 6'h04, d); chk(d, m_en[c], $sformatf("%s enable core%0d", tag, c));
      for (int w = 0; w < 8; w++) begin
        rd(c, 6'(32 + 4*w), d);
        chk(d, m_mb[c][w], $sformatf("%s mbox core%0d w%0d", tag, c, w));
      end
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < NC; c++) r[c] = |(m_st[c] & m_en[c]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, pay, kb;
    for (int c = 0; c < NC; c++) begin
      m_st[c] = '0; m_en[c] = '0;
      for (int w = 0; w < 8; w++) m_mb[c][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk(32'(irq_o), 32'h0, "R1 irq after reset");

    // R9 enable writes
    for (int c = 0; c < NC; c++) begin
      en_we_i = 1; en_core_i = 2'(c);
      en_data_i = (c == 0) ? 32'hFFFF_FFFF : (c == 1) ? 32'h0000_FFFF :
                  (c == 2) ? 32'hFFFF_0000 : 32'h0;
      m_en[c] = en_data_i;
      @(negedge clk);
      en_we_i = 0;
    end
    check_all("R9");

    // R2 / R8 / R12 IPI sweep over every core and vector
    for (int c = 0; c < NC; c++) begin
      for (int v = 0; v < 32; v++) begin
        cmd(1, 0, mk_cmd(32'hDEAD_BEEF, 4'hF, 10'(c), 5'(v)), 0, 0, 0);
        m_st[c] |= 32'h1 << v;
        rd(c, 6'h00, d);
        chk(d, m_st[c], $sformatf("R2 R12 status core%0d vec%0d", c, v));
        @(negedge clk);
        chk(32'(irq_o), 32'(exp_irq()), $sformatf("R8 irq core%0d vec%0d", c, v));
      end
    end
    check_all("R2 others");

    // R7 clear, then set and clear on the same cycle
    cmd(0, 0, '0, 1, 0, 32'h0000_00F0);
    m_st[0] &= ~32'h0000_00F0;
    rd(0, 6'h00, d); chk(d, m_st[0], "R7 clear core0");
    cmd(1, 0, mk_cmd('0, 4'h0, 10'd0, 5'd5), 1, 0, 32'h0000_0FFF);
    m_st[0] = (m_st[0] & ~32'h0000_0FFF) | 32'h20;
    rd(0, 6'h00, d); chk(d, m_st[0], "R7 set wins core0");
    for (int c = 0; c < NC; c++) begin
      cmd(0, 0, '0, 1, c, 32'hFFFF_FFFF);
      m_st[c] = '0;
    end
    @(negedge clk);
    chk(32'(irq_o), 32'h0, "R8 irq low after full clear");
    check_all("R7 full clear");

    // R3 R4 R5 mailbox sweep: all cores, words, masks, two passes
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < NC; c++) begin
        for (int w = 0; w < 8; w++) begin
          for (int m = 0; m < 16; m++) begin
            pay = 32'h1357_9BDF * 32'(p*512 + c*128 + w*16 + m + 1) + 32'(m);
            cmd(1, 1, mk_cmd(pay, 4'(m), 10'(c), {3'(w), 2'b00}), 0, 0, 0);
            for (int b = 0; b < 4; b++) kb[b*8 +: 8] = {8{m[b]}};
            m_mb[c][w] = (m_mb[c][w] & kb) | (pay & ~kb);
            rd(c, 6'(32 + 4*w), d);
            chk(d, m_mb[c][w], $sformatf("%s core%0d w%0d mask%0h", (m == 0) ? "R5" : "R4", c, w, m));
            rd(c, 6'(32 + 4*((w + 1) % 8)), d);
            chk(d, m_mb[c][(w + 1) % 8], $sformatf("R3 neighbour core%0d w%0d", c, (w + 1) % 8));
          end
        end
      end
    end
    check_all("R3 after sweep");

    // R6 out-of-range core numbers, both kinds
    cmd(1, 0, mk_cmd('0, 4'h0, 10'd4, 5'd3), 0, 0, 0);
    cmd(1, 1, mk_cmd(32'hA5A5_A5A5, 4'h0, 10'd1023, 5'b00100), 0, 0, 0);
    cmd(1, 1, mk_cmd(32'h5A5A_5A5A, 4'h0, 10'd516, 5'b00000), 0, 0, 0);
    @(negedge clk);
    chk(32'(irq_o), 32'h0, "R6 irq unchanged");
    check_all("R6");

    // R11 valid low
    cmd(0, 0, mk_cmd('0, 4'h0, 10'd0, 5'd7), 0, 0, 0);
    cmd(0, 1, mk_cmd(32'h1111_2222, 4'h0, 10'd2, 5'b01000), 0, 0, 0);
    @(negedge clk);
    chk(32'(irq_o), 32'h0, "R11 irq unchanged");
    check_all("R11");

    // R10 unmapped offsets
    rd(1, 6'h08, d); chk(d, 32'h0, "R10 offset 08");
    rd(1, 6'h1C, d); chk(d, 32'h0, "R10 offset 1C");
    rd(1, 6'h21, d); chk(d, 32'h0, "R10 offset 21");
    rd(1, 6'h3C, d); chk(d, m_mb[1][7], "R10 offset 3C");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule